// File: doc/BRIEF.md
# Paired 8/16-bit CPU register file

This block holds the architectural registers of a small 8-bit processor: an accumulator, a flag byte, six general byte registers, a 16-bit stack pointer and a 16-bit program counter. The general bytes are also grouped into four 16-bit pairs. A byte written on its own shows up in its pair, and a pair written as one word updates both bytes. Instruction decode and the ALU sit outside and drive the ports.

There are two combinational read ports and one write port. Each of these ports chooses byte or word width with its own select bit. A separate flag port loads the four condition flags and leaves the accumulator alone. The low nibble of the flag byte is not stored and always reads as zero, on every path into it. Reads return the state held before the current edge, so a write becomes visible one cycle later.

Top module: `paired_regfile`

## Requirements
- R1: After reset, word code 5 (PC) reads 0x0000 and word code 4 (SP) reads 0xFFFE. Both values come from parameters. Every byte register reads 0x00.
- R2: In byte mode the 3-bit select codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F, 7=A. A byte write (wr_data[7:0]) to a code reads back from either port on that code after the next clock edge.
- R3: In word mode codes 0..3 are BC, DE, HL and AF. The first-named register is bits 15:8. A word write updates both bytes, and a byte write is visible in the word view.
- R4: Bits 3:0 of F always read as zero, after a byte write to F and after a word write to AF.
- R5: flags_q[3:0] shows F bits 7:4 as {Z, N, H, C}, with Z on bit 7 of F and C on bit 4.
- R6: When flag_we is high, F[7:4] takes flag_d on the next edge, and A keeps its value.
- R7: When the flag port and the write port both target F in the same cycle, the flag port sets F. The write port still updates A in a word write to AF.
- R8: A read that overlaps a write in the same cycle returns the old value. The new value appears after the clock edge.
- R9: Word code 4 is SP and code 5 is PC, and both can be read and written. Word codes 6 and 7 read 0x0000, and a write to them changes no register.
- R10: With wr_en and flag_we low, no register changes, whatever the data and select inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | Write width: 1 = word, 0 = byte |
| wr_sel | input | 3 | Write register code |
| wr_data | input | 16 | Write data (byte mode uses bits 7:0) |
| flag_we | input | 1 | Flag port enable |
| flag_d | input | 4 | New flags {Z,N,H,C} |
| ra_wide | input | 1 | Read port A width |
| ra_sel | input | 3 | Read port A code |
| ra_data | output | 16 | Read port A data (byte mode zero-extended) |
| rb_wide | input | 1 | Read port B width |
| rb_sel | input | 3 | Read port B code |
| rb_data | output | 16 | Read port B data |
| flags_q | output | 4 | Current flags {Z,N,H,C} |

## Verification
The bench builds the block with its default reset values, PC at 0x0000 and SP at 0xFFFE. This makes the reset check on those two registers meaningful, and it lets a stack-pointer write be seen as a change away from the reset value. A behavioural model tracks every register. Each cycle the bench compares both read ports and the flag output against the model before the clock edge, so the old-value rule on overlapping reads and the aliasing between pairs are checked on every transaction.

// File: rtl/paired_regfile.sv
module paired_regfile #(
  parameter logic [15:0] SP_INIT = 16'hFFFE,
  parameter logic [15:0] PC_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic        flag_we,
  input  logic [3:0]  flag_d,
  input  logic        ra_wide,
  input  logic [2:0]  ra_sel,
  output logic [15:0] ra_data,
  input  logic        rb_wide,
  input  logic [2:0]  rb_sel,
  output logic [15:0] rb_data,
  output logic [3:0]  flags_q
);
  logic [7:0]  a_q, b_q, c_q, d_q, e_q, h_q, l_q;
  logic [3:0]  f_hi;
  logic [15:0] sp_q, pc_q;

  logic [7:0] wb;
  logic [7:0] ww;
  always_comb begin
    wb = '0;
    ww = '0;
    if (wr_en && !wr_wide) wb[wr_sel] = 1'b1;
    if (wr_en &&  wr_wide) ww[wr_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0;
      e_q <= '0; h_q <= '0; l_q <= '0; f_hi <= '0;
      sp_q <= SP_INIT;
      pc_q <= PC_INIT;
    end else begin
      if (wb[0]) b_q <= wr_data[7:0];  else if (ww[0]) b_q <= wr_data[15:8];
      if (wb[1]) c_q <= wr_data[7:0];  else if (ww[0]) c_q <= wr_data[7:0];
      if (wb[2]) d_q <= wr_data[7:0];  else if (ww[1]) d_q <= wr_data[15:8];
      if (wb[3]) e_q <= wr_data[7:0];  else if (ww[1]) e_q <= wr_data[7:0];
      if (wb[4]) h_q <= wr_data[7:0];  else if (ww[2]) h_q <= wr_data[15:8];
      if (wb[5]) l_q <= wr_data[7:0];  else if (ww[2]) l_q <= wr_data[7:0];
      if (wb[7]) a_q <= wr_data[7:0];  else if (ww[3]) a_q <= wr_data[15:8];
      if (flag_we)            f_hi <= flag_d;
      else if (wb[6] || ww[3]) f_hi <= wr_data[7:4];
      if (ww[4]) sp_q <= wr_data;
      if (ww[5]) pc_q <= wr_data;
    end
  end

  logic [7:0]  f_byte;
  logic [7:0]  bv [8];
  logic [15:0] wv [8];
  assign f_byte = {f_hi, 4'h0};
  assign bv[0] = b_q; assign bv[1] = c_q; assign bv[2] = d_q; assign bv[3] = e_q;
  assign bv[4] = h_q; assign bv[5] = l_q; assign bv[6] = f_byte; assign bv[7] = a_q;
  assign wv[0] = {b_q, c_q};
  assign wv[1] = {d_q, e_q};
  assign wv[2] = {h_q, l_q};
  assign wv[3] = {a_q, f_byte};
  assign wv[4] = sp_q;
  assign wv[5] = pc_q;
  assign wv[6] = '0;
  assign wv[7] = '0;

  assign ra_data = ra_wide ? wv[ra_sel] : {8'h00, bv[ra_sel]};
  assign rb_data = rb_wide ? wv[rb_sel] : {8'h00, bv[rb_sel]};
  assign flags_q = f_hi;
endmodule

// File: rtl/paired_regfile_chk.sv
module paired_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_wide,
  input logic [2:0]  wr_sel,
  input logic        flag_we,
  input logic [3:0]  flag_d,
  input logic        ra_wide,
  input logic [2:0]  ra_sel,
  input logic [15:0] ra_data,
  input logic [3:0]  flags_q,
  input logic [7:0]  a_q,
  input logic [7:0]  b_q,
  input logic [15:0] sp_q,
  input logic [15:0] pc_q
);
  a_r1_reset_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_q == 16'h0000 && sp_q == 16'hFFFE));

  a_r4_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ra_wide && ra_sel == 3'd6) || (ra_wide && ra_sel == 3'd3)) |-> ra_data[3:0] == 4'h0);

  a_r6_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags_q == $past(flag_d));

  a_r6_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !(wr_en && ((!wr_wide && wr_sel == 3'd7) || (wr_wide && wr_sel == 3'd3))))
      |=> $stable(a_q));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flag_we) |=> ($stable(a_q) && $stable(b_q) && $stable(sp_q)
                              && $stable(pc_q) && $stable(flags_q)));
endmodule

bind paired_regfile paired_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
  .flag_we(flag_we), .flag_d(flag_d), .ra_wide(ra_wide), .ra_sel(ra_sel),
  .ra_data(ra_data), .flags_q(flags_q), .a_q(a_q), .b_q(b_q),
  .sp_q(sp_q), .pc_q(pc_q)
);

// File: tb/paired_regfile_tb_top.sv
module paired_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, wr_wide = 0, flag_we = 0, ra_wide = 0, rb_wide = 0;
  logic [2:0] wr_sel = 0, ra_sel = 0, rb_sel = 0;
  logic [15:0] wr_data = 0;
  logic [3:0] flag_d = 0;
  logic [15:0] ra_data, rb_data;
  logic [3:0] flags_q;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m [8];
  logic [15:0] m_sp, m_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  paired_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_we(flag_we), .flag_d(flag_d),
    .ra_wide(ra_wide), .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_wide(rb_wide), .rb_sel(rb_sel), .rb_data(rb_data), .flags_q(flags_q)
  );

  function automatic logic [15:0] expect_rd(input logic wide, input logic [2:0] s);
    if (!wide) return {8'h00, m[s]};
    case (s)
      3'd0: return {m[0], m[1]};
      3'd1: return {m[2], m[3]};
      3'd2: return {m[4], m[5]};
      3'd3: return {m[7], m[6]};
      3'd4: return m_sp;
      3'd5: return m_pc;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    m_sp = 16'hFFFE;
    m_pc = 16'h0000;
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      model_reset();
      return;
    end
    if (wr_en && !wr_wide) m[wr_sel] = wr_data[7:0];
    if (wr_en && wr_wide) begin
      case (wr_sel)
        3'd0: begin m[0] = wr_data[15:8]; m[1] = wr_data[7:0]; end
        3'd1: begin m[2] = wr_data[15:8]; m[3] = wr_data[7:0]; end
        3'd2: begin m[4] = wr_data[15:8]; m[5] = wr_data[7:0]; end
        3'd3: begin m[7] = wr_data[15:8]; m[6] = wr_data[7:0]; end
        3'd4: m_sp = wr_data;
        3'd5: m_pc = wr_data;
        default: ;
      endcase
    end
    m[6][3:0] = 4'h0;
    if (flag_we) m[6] = {flag_d, 4'h0};
  endtask

  task automatic step(input string req);
    #1;
    chk(req, "ra_data", ra_data, expect_rd(ra_wide, ra_sel));
    chk(req, "rb_data", rb_data, expect_rd(rb_wide, rb_sel));
    chk(req, "flags_q", {12'h0, flags_q}, {12'h0, m[6][7:4]});
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(input logic wide, input logic [2:0] s, input logic [15:0] d);
    wr_en = 1; wr_wide = wide; wr_sel = s; wr_data = d;
  endtask

  task automatic rd(input logic aw, input logic [2:0] as, input logic bw, input logic [2:0] bs);
    ra_wide = aw; ra_sel = as; rb_wide = bw; rb_sel = bs;
  endtask

  task automatic idle();
    wr_en = 0; flag_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    // R1: reset values of SP, PC and bytes
    rd(1, 3'd4, 1, 3'd5); step("R1");
    rd(0, 3'd7, 1, 3'd0); step("R1");
    // R2: every byte code written then read
    for (int i = 0; i < 8; i++) begin
      wr(0, 3'(i), 16'hAA00 | 16'(8'h11 * (i + 1))); rd(0, 3'(i), 0, 3'(i)); step("R2");
    end
    idle();
    for (int i = 0; i < 8; i++) begin rd(0, 3'(i), 1, 3'(i)); step("R2"); end
    // R3: word pairs and byte/word aliasing
    wr(1, 3'd0, 16'h1234); step("R3");
    wr(1, 3'd1, 16'h5678); step("R3");
    wr(1, 3'd2, 16'h9ABC); step("R3");
    idle(); rd(0, 3'd0, 0, 3'd1); step("R3");
    rd(1, 3'd1, 1, 3'd2); step("R3");
    wr(0, 3'd5, 16'h00EE); step("R3");
    idle(); rd(1, 3'd2, 0, 3'd4); step("R3");
    // R4: low nibble of F
    wr(0, 3'd6, 16'h00FF); step("R4");
    idle(); rd(0, 3'd6, 1, 3'd3); step("R4");
    wr(1, 3'd3, 16'hC35A); step("R4");
    idle(); step("R4");
    // R5: flag output bit mapping
    for (int i = 0; i < 4; i++) begin
      wr(0, 3'd6, 16'(8'h10 << i)); step("R5");
    end
    idle(); step("R5");
    // R6: flag port alone leaves A
    wr(0, 3'd7, 16'h0042); step("R6");
    wr_en = 0; flag_we = 1; flag_d = 4'b1010; rd(0, 3'd7, 1, 3'd3); step("R6");
    flag_d = 4'b0101; step("R6");
    idle(); step("R6");
    // R7: flag port wins on F, A still written
    wr(1, 3'd3, 16'h77F0); flag_we = 1; flag_d = 4'b0011; step("R7");
    idle(); step("R7");
    wr(0, 3'd6, 16'h00C0); flag_we = 1; flag_d = 4'b1100; step("R7");
    idle(); step("R7");
    // R8: old value on overlapping read
    wr(0, 3'd0, 16'h00D1); rd(0, 3'd0, 1, 3'd0); step("R8");
    wr(1, 3'd0, 16'hBEEF); step("R8");
    idle(); step("R8");
    // R9: SP/PC and unused word codes
    wr(1, 3'd4, 16'hC000); rd(1, 3'd4, 1, 3'd5); step("R9");
    wr(1, 3'd5, 16'h0150); step("R9");
    wr(1, 3'd6, 16'hFFFF); rd(1, 3'd6, 1, 3'd7); step("R9");
    wr(1, 3'd7, 16'hFFFF); step("R9");
    idle();
    for (int i = 0; i < 8; i++) begin rd(1, 3'(i), 0, 3'(i)); step("R9"); end
    // R10: disabled write port changes nothing
    wr_en = 0; wr_wide = 1; wr_sel = 3'd3; wr_data = 16'h0000; flag_d = 4'hF;
    rd(1, 3'd3, 1, 3'd4); step("R10");
    wr_sel = 3'd4; step("R10");
    wr_wide = 0; wr_sel = 3'd7; step("R10");
    rd(0, 3'd7, 1, 3'd0); step("R10");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule